// File: doc/BRIEF.md
# Phase-Modulated Numerically Controlled Oscillator

This block is a direct digital synthesis core. A 32-bit frequency word sets the step that a 32-bit phase accumulator adds on every system clock. The accumulator is pipelined in 8-bit adder slices. An 8-bit phase-modulation word is added to the top bits of the accumulated phase, and the sum addresses a sine table that yields an 8-bit offset-binary amplitude word for an external DAC. Three single-bit square waves come out alongside it: an in-phase tap, a quadrature tap and a modulated tap. The block also forwards a DAC clock.

The frequency word is loaded by a low-active write strobe that may have no relation to the system clock. The word is captured on the strobe's rising edge and carried into the system clock domain by a toggle handshake. The amplitude and square-wave outputs form a free-running sample stream, one sample per system clock. It has no valid or ready signals, because a DAC cannot apply back-pressure. The consumer takes every sample on the rising edge of the forwarded DAC clock.

Top module: `pm_nco`

## Requirements
- R1: On each system clock edge the reference accumulator A (32 bits, wrapping modulo 2^32) adds the frequency word in effect, so the output frequency is fw × Fclk / 2^32. The outputs present after edge j are computed from A as it stood after edge j-5.
- R2: The 8-bit slice pipeline produces the same top byte as an unpipelined 32-bit accumulator, including carries that ripple up from the lowest byte.
- R3: The modulated index is (A[31:24] + pm_word) mod 256. pm_word is the value sampled at edge j-1 for the outputs present after edge j.
- R4: amp_out equals 128 + round(127 × sin(2π·idx/256)) for the modulated index idx, where round means floor(x + 0.5).
- R5: The rising edge of fw_wr_n captures fw_data. The new word is first added at the fourth system clock edge after that strobe edge. fw_data changes at any other time have no effect. Successive writes must be at least 4 system clocks apart.
- R6: While rst_n is low, the stored frequency word and the phase are cleared at once, without waiting for a clock. During reset amp_out is 128 and all square-wave outputs are 0. After release, and with no write, the output stays at zero phase.
- R7: sq_sin equals bit 31 of A, with the same latency as amp_out.
- R8: sq_cos equals A[31] XOR A[30], which leads sq_sin by a quarter cycle.
- R9: sq_msin equals bit 7 of the modulated index.
- R10: dac_clk is the inverted system clock, so its rising edge falls mid-cycle while the outputs are stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (sampling) clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fw_wr_n | input | 1 | Active-low frequency write strobe; captures on its rising edge; asynchronous |
| fw_data | input | 32 | Frequency control word |
| pm_word | input | 8 | Phase-modulation offset added to the top phase byte |
| amp_out | output | 8 | Offset-binary sine amplitude for the DAC |
| dac_clk | output | 1 | Inverted system clock forwarded to the DAC |
| sq_sin | output | 1 | Square wave from accumulator MSB |
| sq_cos | output | 1 | Quadrature square wave |
| sq_msin | output | 1 | Square wave from the modulated phase MSB |

## Verification
A new frequency word governs the accumulator from the fourth clock edge after the strobe rises. Every output seen after edge j reflects the accumulator five edges earlier and the modulation word from one edge earlier. The bench keeps a reference accumulator that loads the pending word on that exact edge. It holds short histories of the accumulator and of pm_word, indexed by those fixed depths. All outputs are compared at each falling clock edge against the history entries, so every check lands in the cycle the latency count predicts. The reset outputs are checked one time unit after rst_n falls, and dac_clk is checked just after each clock edge.

// File: rtl/pm_nco_pkg.sv
package pm_nco_pkg;

  localparam real TWO_PI = 6.283185307179586;

  // Offset-binary sine level for table entry idx of a 2**aw entry table, dw-bit output
  function automatic int sine_level(int idx, int aw, int dw);
    real ang;
    real peak;
    ang  = TWO_PI * real'(idx) / real'(1 << aw);
    peak = real'((1 << (dw - 1)) - 1);
    return (1 << (dw - 1)) + $rtoi($floor(peak * $sin(ang) + 0.5));
  endfunction

endpackage

// File: rtl/pm_nco_delay.sv
module pm_nco_delay #(
  parameter int W = 8,
  parameter int D = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  // Plain register chain, D >= 1
  logic [D-1:0][W-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr <= '0;
    end else begin
      sr[0] <= din;
      for (int i = 1; i < D; i++) sr[i] <= sr[i-1];
    end
  end

  assign dout = sr[D-1];
endmodule

// File: rtl/pm_nco_fw_sync.sv
module pm_nco_fw_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fw_wr_n,
  input  logic [W-1:0] fw_data,
  output logic [W-1:0] freq_q
);
  logic [W-1:0] hold_q;
  logic         tgl_q;
  logic         s1_q, s2_q, s3_q;
  logic         load;

  // Strobe domain: capture word and flip toggle on rising strobe edge
  always_ff @(posedge fw_wr_n or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      tgl_q  <= 1'b0;
    end else begin
      hold_q <= fw_data;
      tgl_q  <= ~tgl_q;
    end
  end

  // System domain: two-flop synchroniser plus edge detector
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= tgl_q;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign load = s2_q ^ s3_q;

  // hold_q has been stable for two clocks when load is seen
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    freq_q <= '0;
    else if (load) freq_q <= hold_q;
  end
endmodule

// File: rtl/pm_nco_pipe_acc.sv
module pm_nco_pipe_acc #(
  parameter int ACC_W   = 32,
  parameter int SLICE_W = 8,
  parameter int TOP_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ACC_W-1:0] step,
  output logic [TOP_W-1:0] phase_top
);
  localparam int NS        = ACC_W / SLICE_W;
  localparam int NTOP      = TOP_W / SLICE_W;
  localparam int FIRST_TOP = NS - NTOP;

  logic [NS-2:0] carry;

  for (genvar k = 0; k < NS; k++) begin : g_slice
    logic [SLICE_W-1:0] step_k;
    logic [SLICE_W-1:0] acc_q;
    logic               cin;

    // Slice k runs k cycles behind slice 0, so its step is delayed to match
    if (k == 0) begin : g_step_now
      assign step_k = step[SLICE_W-1:0];
    end else begin : g_step_dly
      pm_nco_delay #(.W(SLICE_W), .D(k)) u_step_dly (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (step[k*SLICE_W +: SLICE_W]),
        .dout (step_k)
      );
    end

    if (k == 0) begin : g_cin0
      assign cin = 1'b0;
    end else begin : g_cin
      assign cin = carry[k-1];
    end

    if (k == NS - 1) begin : g_msb
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_q + step_k + SLICE_W'(cin);
      end
    end else begin : g_mid
      logic [SLICE_W:0] sum;
      logic             cy_q;
      assign sum = {1'b0, acc_q} + {1'b0, step_k} + {{SLICE_W{1'b0}}, cin};
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) {cy_q, acc_q} <= '0;
        else        {cy_q, acc_q} <= sum;
      end
      assign carry[k] = cy_q;
    end

    // De-skew only the slices that feed the output
    if (k >= FIRST_TOP) begin : g_out
      if (k == NS - 1) begin : g_align_now
        assign phase_top[(k-FIRST_TOP)*SLICE_W +: SLICE_W] = acc_q;
      end else begin : g_align_dly
        pm_nco_delay #(.W(SLICE_W), .D(NS - 1 - k)) u_deskew (
          .clk  (clk),
          .rst_n(rst_n),
          .din  (acc_q),
          .dout (phase_top[(k-FIRST_TOP)*SLICE_W +: SLICE_W])
        );
      end
    end
  end
endmodule

// File: rtl/pm_nco_sine_rom.sv
module pm_nco_sine_rom #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  output logic [DW-1:0] amp
);
  localparam int DEPTH = 1 << AW;
  localparam logic [DW-1:0] MID = DW'(1 << (DW - 1));

  logic [DW-1:0] tbl [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_rom
    localparam int LVL = pm_nco_pkg::sine_level(i, AW, DW);
    assign tbl[i] = DW'(LVL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) amp <= MID;
    else        amp <= tbl[addr];
  end
endmodule

// File: rtl/pm_nco.sv
module pm_nco #(
  parameter int ACC_W   = 32,
  parameter int SLICE_W = 8,
  parameter int PM_W    = 8,
  parameter int AMP_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fw_wr_n,
  input  logic [ACC_W-1:0] fw_data,
  input  logic [PM_W-1:0]  pm_word,
  output logic [AMP_W-1:0] amp_out,
  output logic             dac_clk,
  output logic             sq_sin,
  output logic             sq_cos,
  output logic             sq_msin
);
  logic [ACC_W-1:0] freq_q;
  logic [PM_W-1:0]  ph_top;
  logic [PM_W-1:0]  mod_q;
  logic             sin_a, cos_a;

  pm_nco_fw_sync #(.W(ACC_W)) u_fw_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .fw_wr_n(fw_wr_n),
    .fw_data(fw_data),
    .freq_q (freq_q)
  );

  pm_nco_pipe_acc #(.ACC_W(ACC_W), .SLICE_W(SLICE_W), .TOP_W(PM_W)) u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (freq_q),
    .phase_top(ph_top)
  );

  // Stage A: phase offset and raw quadrature taps
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mod_q <= '0;
      sin_a <= 1'b0;
      cos_a <= 1'b0;
    end else begin
      mod_q <= ph_top + pm_word;
      sin_a <= ph_top[PM_W-1];
      cos_a <= ph_top[PM_W-1] ^ ph_top[PM_W-2];
    end
  end

  // Stage B: table lookup, square waves kept in step with it
  pm_nco_sine_rom #(.AW(PM_W), .DW(AMP_W)) u_rom (
    .clk  (clk),
    .rst_n(rst_n),
    .addr (mod_q),
    .amp  (amp_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sq_sin  <= 1'b0;
      sq_cos  <= 1'b0;
      sq_msin <= 1'b0;
    end else begin
      sq_sin  <= sin_a;
      sq_cos  <= cos_a;
      sq_msin <= mod_q[PM_W-1];
    end
  end

  assign dac_clk = ~clk;
endmodule

// File: rtl/pm_nco_chk.sv
module pm_nco_chk #(
  parameter int ACC_W = 32,
  parameter int PM_W  = 8,
  parameter int AMP_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [ACC_W-1:0] freq_q,
  input logic [PM_W-1:0]  ph_top,
  input logic [PM_W-1:0]  pm_word,
  input logic [AMP_W-1:0] amp_out,
  input logic             sq_sin,
  input logic             sq_cos,
  input logic             sq_msin
);
  localparam logic [AMP_W-1:0] MID = AMP_W'(1 << (AMP_W - 1));

  logic [2:0] since_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              since_q <= '0;
    else if (since_q != 3'd7) since_q <= since_q + 3'd1;
  end

  // R2: top byte advances by the word's top byte plus at most one lower carry
  assert_phase_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (since_q >= 3'd6) |->
      (PM_W'(ph_top - $past(ph_top) - $past(freq_q[ACC_W-1 -: PM_W], 4)) <= PM_W'(1)));

  // R7: in-phase tap follows the accumulator MSB two stages later
  assert_sin_tap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (since_q >= 3'd3) |-> (sq_sin == $past(ph_top[PM_W-1], 2)));

  // R8: quadrature tap
  assert_cos_tap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (since_q >= 3'd3) |-> (sq_cos == ($past(ph_top[PM_W-1], 2) ^ $past(ph_top[PM_W-2], 2))));

  // R9 / R3: modulated tap is MSB of phase plus offset
  assert_msin_tap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (since_q >= 3'd3) |->
      (sq_msin == PM_W'($past(ph_top, 2) + $past(pm_word, 2)) >> (PM_W - 1)));

  // R6: reset state
  assert_reset_state_R6: assert property (@(posedge clk)
    (!rst_n) |-> (amp_out == MID && !sq_sin && !sq_cos && !sq_msin && freq_q == '0));
endmodule

bind pm_nco pm_nco_chk #(.ACC_W(ACC_W), .PM_W(PM_W), .AMP_W(AMP_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .freq_q (freq_q),
  .ph_top (ph_top),
  .pm_word(pm_word),
  .amp_out(amp_out),
  .sq_sin (sq_sin),
  .sq_cos (sq_cos),
  .sq_msin(sq_msin)
);

// File: tb/tb_pm_nco.sv
module tb_pm_nco;
  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        fw_wr_n = 1'b1;
  logic [31:0] fw_data = '0;
  logic [7:0]  pm_word = '0;
  logic [7:0]  amp_out;
  logic        dac_clk, sq_sin, sq_cos, sq_msin;

  int checks = 0;
  int errors = 0;

  pm_nco dut (
    .clk(clk), .rst_n(rst_n), .fw_wr_n(fw_wr_n), .fw_data(fw_data),
    .pm_word(pm_word), .amp_out(amp_out), .dac_clk(dac_clk),
    .sq_sin(sq_sin), .sq_cos(sq_cos), .sq_msin(sq_msin)
  );

  always #5 clk = ~clk;

  // Reference model built from R1, R3, R5
  logic [31:0] acc_m = '0, f_m = '0, pend = '0;
  int          ld_cnt = 0;
  logic [31:0] hist [0:5];
  logic [7:0]  pmh  [0:1];
  initial begin
    for (int i = 0; i < 6; i++) hist[i] = '0;
    pmh[0] = '0; pmh[1] = '0;
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_m <= '0; f_m <= '0; ld_cnt <= 0;
      for (int i = 0; i < 6; i++) hist[i] <= '0;
      pmh[0] <= '0; pmh[1] <= '0;
    end else begin
      acc_m   <= acc_m + f_m;
      hist[0] <= acc_m + f_m;
      for (int i = 1; i < 6; i++) hist[i] <= hist[i-1];
      if (ld_cnt == 1) f_m <= pend;
      if (ld_cnt != 0) ld_cnt <= ld_cnt - 1;
      pmh[0] <= pm_word;
      pmh[1] <= pmh[0];
    end
  end

  function automatic int sine_ref(int idx);
    real ang;
    ang = 6.283185307179586 * real'(idx) / real'(256);
    return 128 + $rtoi($floor(127.0 * $sin(ang) + 0.5));
  endfunction

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Compare all outputs against the model history (R1 latency: A after edge j-5)
  task automatic sample(string req);
    logic [7:0] top, idx;
    top = hist[5][31:24];
    idx = top + pmh[1];
    check(req, "amp_out R4", int'(amp_out), sine_ref(int'(idx)));
    check(req, "sq_sin R7", int'(sq_sin), int'(top[7]));
    check(req, "sq_cos R8", int'(sq_cos), int'(top[7] ^ top[6]));
    check(req, "sq_msin R9", int'(sq_msin), int'(idx[7]));
  endtask

  task automatic run(int n, string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sample(req);
    end
  endtask

  // R5: word captured on the strobe's rising edge; junk on fw_data around it
  task automatic write_freq(logic [31:0] val, string req);
    @(negedge clk); sample(req);
    fw_data = ~val;
    fw_wr_n = 1'b0;
    @(negedge clk); sample(req);
    fw_data = val;
    #1 fw_wr_n = 1'b1;
    pend   = val;
    ld_cnt = 3;
    #1 fw_data = val ^ 32'h5A5A_A5A5;
  endtask

  task automatic do_reset(string req);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(req, "reset amp R6", int'(amp_out), 128);
    check(req, "reset sin R6", int'(sq_sin), 0);
    check(req, "reset cos R6", int'(sq_cos), 0);
    check(req, "reset msin R6", int'(sq_msin), 0);
    repeat (6) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset_idle;
    pm_word = 8'h00;
    do_reset("R6");
    run(12, "R6");                // no write: stays at zero phase, amp 128
    fw_data = 32'hDEAD_BEEF;      // data moves without a strobe: ignored (R5)
    run(10, "R5");
  endtask

  task automatic t_basic_tone;
    write_freq(32'h0100_0000, "R1");
    run(300, "R1");               // full top-byte wrap covered
  endtask

  task automatic t_carry;
    write_freq(32'h00C0_0001, "R2");
    run(120, "R2");
    write_freq(32'h0000_FF80, "R2");
    run(150, "R2");
    write_freq(32'hFFFF_FFFF, "R2");
    run(40, "R2");
  endtask

  task automatic t_phase_mod;
    write_freq(32'h0280_0000, "R3");
    run(8, "R3");
    pm_word = 8'h40; run(20, "R3");
    pm_word = 8'h80; run(20, "R9");
    pm_word = 8'hFF; run(20, "R3");
    pm_word = 8'h00; run(8, "R3");
  endtask

  task automatic t_strobe_timing;
    write_freq(32'h0000_0000, "R5");
    run(10, "R5");
    write_freq(32'h0300_0000, "R5");
    for (int i = 0; i < 10; i++) begin
      fw_data = 32'h1234_0000 + 32'(i);   // strobe high: must not change the tone
      @(negedge clk); sample("R5");
    end
    write_freq(32'h7F00_0000, "R5");
    run(30, "R5");
  endtask

  task automatic t_dac_clk;
    for (int i = 0; i < 6; i++) begin
      @(posedge clk); #1;
      check("R10", "dac_clk after rise", int'(dac_clk), 0);
      @(negedge clk); #1;
      check("R10", "dac_clk after fall", int'(dac_clk), 1);
    end
  endtask

  task automatic t_reset_midrun;
    write_freq(32'h0123_4567, "R6");
    run(20, "R6");
    pm_word = 8'h00;
    do_reset("R6");
    run(15, "R6");
  endtask

  initial begin
    #2 rst_n = 1'b0;
    #30 rst_n = 1'b1;
    @(negedge clk);
    check("R6", "initial amp R6", int'(amp_out), 128);
    t_reset_idle();
    t_basic_tone();
    t_carry();
    t_phase_mod();
    t_strobe_timing();
    t_dac_clk();
    t_reset_midrun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_500_000;
    checks++;
    errors++;
    $display("FAIL watchdog expired at %0t", $time);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule